// File: doc/BRIEF.md
# Pin I/O Controller with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O peripheral that sits on a simple word-wide register bus (byte address, write strobe, write data, combinational read data). Software sets the direction of each pin and changes output levels. It never writes the output word directly. It writes ones into a set register or a clear register, so bits written as zero keep their value. The current pin levels can be read back after they pass through a synchronizer.

Every pin has its own event detector. Three bit-vector registers select the trigger for each pin:
- a method vector chooses edge or level detection;
- a dual-edge vector chooses one edge or both edges;
- a polarity vector chooses rising or active-high for 0, and falling or active-low for 1.

Each detected event sets a sticky bit in a raw status word. Software clears these bits by writing ones. The raw bits are qualified by an enable vector and a mask vector to form the masked status. The OR of all masked bits drives a single interrupt line for the whole controller.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: A read at offset 0x04 returns the pin levels seen through a two-flop synchronizer. A pin change made before clock edge k is visible in the read data after edge k+1.
- R2: A write to offset 0x10 drives high every output whose bit is 1. A write to offset 0x14 drives low every output whose bit is 1. Bits written as 0 leave their outputs unchanged. The output word is visible on pin_out and at offset 0x00, and changes on no other access.
- R3: Offset 0x08 holds the direction vector (1 = output). It drives pin_oe directly and reads back as written.
- R4: With method bit 0 (edge) and dual-edge bit 0, polarity 0 sets the raw status bit (offset 0x24) on a rising edge, and polarity 1 sets it on a falling edge. The bit is set one cycle after the edge reaches the synchronizer output. It stays set after the pin returns to its previous level.
- R5: With method bit 0 and dual-edge bit 1 (offset 0x38), both a rising edge and a falling edge set the raw status bit, whatever the polarity bit is.
- R6: With method bit 1 (offset 0x34), polarity 0 sets the raw bit on every cycle that the synchronized pin is high, and polarity 1 on every cycle that it is low. A clear therefore does not remove the bit while the active level persists.
- R7: Writing ones to offset 0x30 clears the matching raw status bits, and bits written as zero are untouched. When an event and a clear reach the same bit in the same cycle, the bit ends up set.
- R8: Offset 0x28 reads raw AND enable (offset 0x20) AND NOT mask (offset 0x2C). irq_out is high exactly when any masked bit is high.
- R9: After reset, all configuration, output and status registers read zero, and pin_out, pin_oe and irq_out are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32 | Asynchronous pin levels from the pads |
| pin_out | output | 32 | Output level per pin |
| pin_oe | output | 32 | Output enable per pin (1 = drive) |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions run on every cycle and cover these rules:
- a set or clear write forces exactly the chosen output bits, and pin_out holds still on all other cycles;
- a direction write appears on pin_oe;
- raw status bits only disappear through a clear write;
- a detected event always leaves its bit set, even when a clear arrives in the same cycle;
- the interrupt line goes quiet whenever nothing is enabled.

Some behaviour only the bench's scenarios can show, because it needs chosen pin waveforms and cycle counts. This covers the trigger choice for each configuration, the two-cycle synchronizer latency, the level-mode re-assertion right after a clear, and the exact timing of the collision between a clear and an edge. A behavioural model, compared on every clock, covers all of these at once.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam logic [7:0] OFS_DOUT   = 8'h00;
  localparam logic [7:0] OFS_PINS   = 8'h04;
  localparam logic [7:0] OFS_DIR    = 8'h08;
  localparam logic [7:0] OFS_SET    = 8'h10;
  localparam logic [7:0] OFS_CLR    = 8'h14;
  localparam logic [7:0] OFS_EN     = 8'h20;
  localparam logic [7:0] OFS_RAW    = 8'h24;
  localparam logic [7:0] OFS_MSKST  = 8'h28;
  localparam logic [7:0] OFS_MASK   = 8'h2C;
  localparam logic [7:0] OFS_STCLR  = 8'h30;
  localparam logic [7:0] OFS_METH   = 8'h34;
  localparam logic [7:0] OFS_DUAL   = 8'h38;
  localparam logic [7:0] OFS_POL    = 8'h3C;

  // Trigger decision for one pin: lvl_mode=1 level, dual=1 both edges,
  // pol=0 rising/high, pol=1 falling/low.
  function automatic logic trig_hit(input logic lvl_mode, input logic dual,
                                    input logic pol, input logic cur,
                                    input logic prv);
    logic hit;
    if (lvl_mode)      hit = cur ^ pol;
    else if (dual)     hit = cur ^ prv;
    else if (pol)      hit = prv & ~cur;
    else               hit = cur & ~prv;
    return hit;
  endfunction

  // Sticky status update: an event wins over a same-cycle clear.
  function automatic logic stat_next(input logic cur, input logic clr,
                                     input logic evt);
    return (cur & ~clr) | evt;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int N      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [N-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
  import gpio_irq_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] lvl_mode,
  input  logic [N-1:0] dual,
  input  logic [N-1:0] pol,
  output logic [N-1:0] evt
);

  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign evt[i] = trig_hit(lvl_mode[i], dual[i], pol[i], lvl[i], prev_q[i]);
  end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
  import gpio_irq_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  input  logic [N-1:0] mask,
  output logic [N-1:0] raw,
  output logic [N-1:0] masked,
  output logic         irq
);

  logic [N-1:0] raw_nx;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign raw_nx[i] = stat_next(raw[i], clr[i], evt[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw <= '0;
    else        raw <= raw_nx;
  end

  assign masked = raw & en & ~mask;
  assign irq    = |masked;

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPIN        = 32,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic              irq_out
);

  logic [NPIN-1:0] dout_q, dir_q, en_q, mask_q, meth_q, dual_q, pol_q;
  logic [NPIN-1:0] pin_lvl, pin_evt, raw_st, msk_st, st_clr;
  logic [NPIN-1:0] wd;

  assign wd = bus_wdata[NPIN-1:0];

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  logic wr_set, wr_clr, wr_dir, wr_en, wr_mask, wr_stclr, wr_meth, wr_dual, wr_pol;
  assign wr_set   = bus_we && hit(bus_addr, OFS_SET);
  assign wr_clr   = bus_we && hit(bus_addr, OFS_CLR);
  assign wr_dir   = bus_we && hit(bus_addr, OFS_DIR);
  assign wr_en    = bus_we && hit(bus_addr, OFS_EN);
  assign wr_mask  = bus_we && hit(bus_addr, OFS_MASK);
  assign wr_stclr = bus_we && hit(bus_addr, OFS_STCLR);
  assign wr_meth  = bus_we && hit(bus_addr, OFS_METH);
  assign wr_dual  = bus_we && hit(bus_addr, OFS_DUAL);
  assign wr_pol   = bus_we && hit(bus_addr, OFS_POL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
    end else if (wr_set) begin
      dout_q <= dout_q | wd;
    end else if (wr_clr) begin
      dout_q <= dout_q & ~wd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      en_q   <= '0;
      mask_q <= '0;
      meth_q <= '0;
      dual_q <= '0;
      pol_q  <= '0;
    end else begin
      if (wr_dir)  dir_q  <= wd;
      if (wr_en)   en_q   <= wd;
      if (wr_mask) mask_q <= wd;
      if (wr_meth) meth_q <= wd;
      if (wr_dual) dual_q <= wd;
      if (wr_pol)  pol_q  <= wd;
    end
  end

  assign st_clr = wr_stclr ? wd : '0;

  gpio_sync #(.N(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_lvl)
  );

  gpio_edge_detect #(.N(NPIN)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (pin_lvl),
    .lvl_mode (meth_q),
    .dual     (dual_q),
    .pol      (pol_q),
    .evt      (pin_evt)
  );

  gpio_irq_status #(.N(NPIN)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (pin_evt),
    .clr    (st_clr),
    .en     (en_q),
    .mask   (mask_q),
    .raw    (raw_st),
    .masked (msk_st),
    .irq    (irq_out)
  );

  always_comb begin
    bus_rdata = '0;
    if      (hit(bus_addr, OFS_DOUT))  bus_rdata = DATA_W'(dout_q);
    else if (hit(bus_addr, OFS_PINS))  bus_rdata = DATA_W'(pin_lvl);
    else if (hit(bus_addr, OFS_DIR))   bus_rdata = DATA_W'(dir_q);
    else if (hit(bus_addr, OFS_EN))    bus_rdata = DATA_W'(en_q);
    else if (hit(bus_addr, OFS_RAW))   bus_rdata = DATA_W'(raw_st);
    else if (hit(bus_addr, OFS_MSKST)) bus_rdata = DATA_W'(msk_st);
    else if (hit(bus_addr, OFS_MASK))  bus_rdata = DATA_W'(mask_q);
    else if (hit(bus_addr, OFS_METH))  bus_rdata = DATA_W'(meth_q);
    else if (hit(bus_addr, OFS_DUAL))  bus_rdata = DATA_W'(dual_q);
    else if (hit(bus_addr, OFS_POL))   bus_rdata = DATA_W'(pol_q);
  end

  assign pin_out = dout_q;
  assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPIN   = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NPIN-1:0]   pin_out,
  input logic [NPIN-1:0]   pin_oe,
  input logic              irq_out,
  input logic [NPIN-1:0]   raw_st,
  input logic [NPIN-1:0]   en_q,
  input logic [NPIN-1:0]   pin_evt,
  input logic [NPIN-1:0]   st_clr
);

  logic is_set, is_clr, is_dir;
  assign is_set = bus_we && bus_addr == ADDR_W'(OFS_SET);
  assign is_clr = bus_we && bus_addr == ADDR_W'(OFS_CLR);
  assign is_dir = bus_we && bus_addr == ADDR_W'(OFS_DIR);

  // R2
  out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_set |=> ((pin_out & $past(bus_wdata[NPIN-1:0])) == $past(bus_wdata[NPIN-1:0])));

  // R2
  out_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_clr |=> ((pin_out & $past(bus_wdata[NPIN-1:0])) == '0));

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_set || is_clr) |=> $stable(pin_out));

  // R3
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_dir |=> pin_oe == $past(bus_wdata[NPIN-1:0]));

  // R7
  raw_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_clr == '0) |=> ((raw_st & $past(raw_st)) == $past(raw_st)));

  // R7
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_evt != '0) |=> ((raw_st & $past(pin_evt)) == $past(pin_evt)));

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0 || raw_st == '0) |-> !irq_out);

endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq_out   (irq_out),
  .raw_st    (raw_st),
  .en_q      (en_q),
  .pin_evt   (pin_evt),
  .st_clr    (st_clr)
);

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  gpio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_out, m_dir, m_en, m_mask, m_meth, m_dual, m_pol, m_raw;
  logic [31:0] hist[$];   // hist[0] newest pad sample, hist[1] synced, hist[2] previous synced

  always @(posedge clk) begin
    if (!rst_n) begin
      m_out = 0; m_dir = 0; m_en = 0; m_mask = 0;
      m_meth = 0; m_dual = 0; m_pol = 0; m_raw = 0;
      hist = '{32'h0, 32'h0, 32'h0};
    end else begin
      logic [31:0] ev, clrv;
      ev = 0; clrv = 0;
      for (int i = 0; i < 32; i++) begin
        bit now_v, was_v;
        now_v = hist[1][i];
        was_v = hist[2][i];
        if (m_meth[i])       ev[i] = m_pol[i] ? !now_v : now_v;
        else if (m_dual[i])  ev[i] = (now_v != was_v);
        else if (m_pol[i])   ev[i] = (was_v && !now_v);
        else                 ev[i] = (!was_v && now_v);
      end
      if (bus_we) begin
        case (bus_addr)
          8'h10: m_out  = m_out | bus_wdata;
          8'h14: m_out  = m_out & ~bus_wdata;
          8'h08: m_dir  = bus_wdata;
          8'h20: m_en   = bus_wdata;
          8'h2C: m_mask = bus_wdata;
          8'h30: clrv   = bus_wdata;
          8'h34: m_meth = bus_wdata;
          8'h38: m_dual = bus_wdata;
          8'h3C: m_pol  = bus_wdata;
          default: ;
        endcase
      end
      m_raw = (m_raw & ~clrv) | ev;
      hist.push_front(pin_in);
      void'(hist.pop_back());
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return m_out;
      8'h04: return hist[1];
      8'h08: return m_dir;
      8'h20: return m_en;
      8'h24: return m_raw;
      8'h28: return m_raw & m_en & ~m_mask;
      8'h2C: return m_mask;
      8'h34: return m_meth;
      8'h38: return m_dual;
      8'h3C: return m_pol;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00: return "R2";
      8'h04: return "R1";
      8'h08: return "R3";
      8'h24: return "R4";
      8'h28: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      chk("R2", "pin_out", pin_out, m_out);
      chk("R3", "pin_oe", pin_oe, m_dir);
      chk("R8", "irq_out", {31'b0, irq_out}, {31'b0, (m_raw & m_en & ~m_mask) != 0});
      chk(tag_of(bus_addr), "rdata", bus_rdata, m_read(bus_addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic setpin(input int idx, input bit v);
    @(negedge clk);
    pin_in[idx] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R9 reset values
    rd(8'h00, v); chk("R9", "dout reset", v, 0);
    rd(8'h08, v); chk("R9", "dir reset", v, 0);
    rd(8'h24, v); chk("R9", "raw reset", v, 0);
    chk("R9", "irq reset", {31'b0, irq_out}, 0);

    // R2 set / clear outputs
    wr(8'h10, 32'h0000_00A5);
    rd(8'h00, v); chk("R2", "set ones", v, 32'h0000_00A5);
    wr(8'h14, 32'h0000_0005);
    rd(8'h00, v); chk("R2", "clear ones", v, 32'h0000_00A0);
    chk("R2", "pin_out", pin_out, 32'h0000_00A0);

    // R3 direction
    wr(8'h08, 32'hFFFF_0000);
    rd(8'h08, v); chk("R3", "dir readback", v, 32'hFFFF_0000);
    chk("R3", "pin_oe", pin_oe, 32'hFFFF_0000);

    // R1 pin readback (high bits stay unconfigured rising: clear after)
    @(negedge clk); pin_in[31:16] = 16'h1234;
    idle(2);
    rd(8'h04, v); chk("R1", "pin levels", v, 32'h1234_0000);
    wr(8'h30, 32'hFFFF_FFFF);

    // R4 rising on pin 0
    setpin(0, 1); idle(4);
    rd(8'h24, v); chk("R4", "rising sets", v, 32'h1);
    setpin(0, 0); idle(4);
    rd(8'h24, v); chk("R4", "sticky after fall", v, 32'h1);
    wr(8'h30, 32'h1);
    rd(8'h24, v); chk("R7", "clear raw", v, 0);

    // R4 falling on pin 1
    wr(8'h3C, 32'h2);
    setpin(1, 1); idle(4);
    rd(8'h24, v); chk("R4", "falling ignores rise", v, 0);
    setpin(1, 0); idle(4);
    rd(8'h24, v); chk("R4", "falling sets", v, 32'h2);
    wr(8'h30, 32'h2);

    // R5 both edges on pin 2
    wr(8'h38, 32'h4);
    setpin(2, 1); idle(4);
    rd(8'h24, v); chk("R5", "both rise", v, 32'h4);
    wr(8'h30, 32'h4);
    setpin(2, 0); idle(4);
    rd(8'h24, v); chk("R5", "both fall", v, 32'h4);
    wr(8'h30, 32'h4);

    // R6 level high on pin 3
    wr(8'h34, 32'h8);
    setpin(3, 1); idle(4);
    rd(8'h24, v); chk("R6", "level high sets", v, 32'h8);
    wr(8'h30, 32'h8);
    rd(8'h24, v); chk("R6", "level reasserts after clear", v, 32'h8);
    setpin(3, 0); idle(4);
    wr(8'h30, 32'h8);
    rd(8'h24, v); chk("R6", "level gone clears", v, 0);

    // R6 level low on pin 4 (pin already low)
    wr(8'h3C, 32'h12);
    wr(8'h34, 32'h18);
    idle(2);
    rd(8'h24, v); chk("R6", "level low sets", v, 32'h10);
    setpin(4, 1); idle(4);
    wr(8'h30, 32'h10);
    rd(8'h24, v); chk("R6", "level low released", v, 0);

    // R8 enable / mask gating with pin 0 rising
    wr(8'h20, 32'h1);
    setpin(0, 1); idle(4);
    chk("R8", "irq enabled", {31'b0, irq_out}, 1);
    rd(8'h28, v); chk("R8", "masked status", v, 32'h1);
    wr(8'h2C, 32'h1);
    chk("R8", "irq masked off", {31'b0, irq_out}, 0);
    rd(8'h28, v); chk("R8", "masked status gated", v, 0);
    wr(8'h2C, 32'h0);
    wr(8'h20, 32'h0);
    chk("R8", "irq disabled", {31'b0, irq_out}, 0);

    // R7 zero bits untouched: raw has bit0, add bit2 via both-edge
    setpin(2, 1); idle(4);
    wr(8'h30, 32'h1);
    rd(8'h24, v); chk("R7", "zero bits kept", v, 32'h4);
    wr(8'h30, 32'h4);

    // R7 event beats same-cycle clear on pin 5 (rising)
    @(negedge clk); pin_in[5] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_we = 1'b1; bus_addr = 8'h30; bus_wdata = 32'h20;
    @(negedge clk); bus_we = 1'b0;
    rd(8'h24, v); chk("R7", "event wins over clear", v, 32'h20);
    wr(8'h30, 32'h20);
    rd(8'h24, v); chk("R7", "later clear works", v, 0);

    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule